// File: doc/BRIEF.md
# PCI Express Configuration Window Decoder

This block owns the 64-bit programmable register that places the memory-mapped PCI Express configuration window in the system address map. Software updates the register through a configuration write port. Each write carries 32 bits of data, a select for the upper or lower half, and four byte enables. From the stored value the block derives an enable, one of three window lengths, and a base address that is aligned to the chosen length.

A memory address presented on the lookup port is compared with the window without waiting for a clock. On a hit, the block reports the offset into the window split into the fields a configuration access needs: bus number, device, function and register offset. The bus field keeps only as many bits as the window length can hold.

The length field sets the window size and also controls how many low base bits take part in the match. A reserved length code raises an error flag and blocks every hit. Bits of the register above the base field are stored but play no part in decoding.

Top module: `cfg_window_decoder`

## Requirements
- R1: Reset loads the register with the parameter value RST_VAL. By default this is base 0xB000_0000, length code 0 and enable clear.
- R2: Register bit 0 is the window enable. While it is 0, win_hit stays 0 for every address, and win_en follows bit 0.
- R3: Register bits [2:1] hold the length code. Code 0 gives a 256 MB window, code 1 gives 128 MB and code 2 gives 64 MB.
- R4: Length code 3 is reserved. It drives win_err to 1 and holds win_hit at 0. win_err is 0 for the other codes.
- R5: win_base equals the register ANDed with a mask. The mask keeps bits [38:28]. It also keeps bit 27 for code 1, and bits 27 and 26 for code 2. Every other bit of win_base is 0.
- R6: win_hit is 1 exactly when the enable is set, the code is not reserved and mem_addr lies in [win_base, win_base + size). An address with a bit set above bit 38 never hits.
- R7: On a hit, tgt_reg = offset[11:0], tgt_fn = offset[14:12] and tgt_dev = offset[19:15]. tgt_bus = offset[27:20] for 256 MB, offset[26:20] for 128 MB and offset[25:20] for 64 MB, zero-extended to 8 bits. Here offset = mem_addr - win_base.
- R8: While win_hit is 0, tgt_bus, tgt_dev, tgt_fn and tgt_reg are all 0.
- R9: cfg_wr_hi = 0 selects register bits [31:0] and cfg_wr_hi = 1 selects bits [63:32]. cfg_wr_be[k] enables data byte k into byte k of the selected half. Unselected bytes keep their value. The decode outputs reflect the new value from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_hi | input | 1 | Half select: 0 = bits [31:0], 1 = bits [63:32] |
| cfg_wr_data | input | 32 | Write data for the selected half |
| cfg_wr_be | input | 4 | Byte enables within the selected half |
| cfg_q | output | 64 | Stored register value |
| win_en | output | 1 | Window enable bit |
| win_err | output | 1 | Reserved length code present |
| win_base | output | ADDR_W | Aligned window base |
| mem_addr | input | ADDR_W | Memory address to test |
| win_hit | output | 1 | Address falls inside the enabled window |
| tgt_bus | output | 8 | Bus number of the hit |
| tgt_dev | output | 5 | Device number of the hit |
| tgt_fn | output | 3 | Function number of the hit |
| tgt_reg | output | 12 | Register offset of the hit |

## Verification
The hardest case to reach is a single-byte write that changes only the length code. The window shrinks, so a base bit that was masked away before now counts, while the upper byte still holds an older base. The stimulus walks the register through a sequence of one-byte writes to set this up. It then probes addresses just inside and just outside each shrinking boundary, and addresses with bits set above the base field. A randomized phase follows, with mixed half writes and addresses clustered around the current base. A behavioural model computes the expected outputs with arithmetic range tests and compares them with the design on every clock.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  // Log2 of the largest and smallest window sizes
  localparam int WIN_MAX_LOG2 = 28;
  localparam int WIN_MIN_LOG2 = 26;
  // Field positions of a configuration offset inside the window
  localparam int BUS_LSB = 20;
  localparam int DEV_LSB = 15;
  localparam int FN_LSB  = 12;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 12;

  typedef enum logic [1:0] {
    LEN_256M = 2'd0,
    LEN_128M = 2'd1,
    LEN_64M  = 2'd2,
    LEN_RSVD = 2'd3
  } win_len_e;
endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
  parameter logic [63:0] RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_be,
  output logic [63:0] q
);
  localparam int NBYTES = 8;
  localparam int HALF_BYTES = NBYTES / 2;

  logic [NBYTES-1:0] byte_we;
  logic [63:0]       nxt_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic HALF_SEL = (b >= HALF_BYTES);
    assign byte_we[b] = wr_en && (wr_hi == HALF_SEL) && wr_be[b % HALF_BYTES];
    assign nxt_q[b*8 +: 8] = wr_data[(b % HALF_BYTES)*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (byte_we[b]) q[b*8 +: 8] <= nxt_q[b*8 +: 8];
      end
    end
  end

  // R9: a write to one half leaves the other half untouched
  a_r9_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> $stable(q[63:32]));
  a_r9_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> $stable(q[31:0]));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/cfgwin_size_decode.sv
module cfgwin_size_decode
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int BASE_MSB = 38
) (
  input  logic [63:0]       cfg,
  output logic              en,
  output logic              err,
  output win_len_e          len,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] mask;

  assign en  = cfg[0];
  assign len = win_len_e'(cfg[2:1]);
  assign err = (len == LEN_RSVD);

  // Base mask: high bits always kept, low bits kept as the window shrinks
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i > BASE_MSB) begin : g_above
      assign mask[i] = 1'b0;
    end else if (i >= WIN_MAX_LOG2) begin : g_fixed
      assign mask[i] = 1'b1;
    end else if (i >= WIN_MIN_LOG2) begin : g_var
      assign mask[i] = (cfg[2:1] >= 2'(WIN_MAX_LOG2 - i));
    end else begin : g_below
      assign mask[i] = 1'b0;
    end
  end

  assign base = cfg[ADDR_W-1:0] & mask;
endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              err,
  input  win_len_e          len,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [BUS_W-1:0]  bus,
  output logic [DEV_W-1:0]  dev,
  output logic [FN_W-1:0]   fn,
  output logic [REG_W-1:0]  reg_off
);
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] off;
  logic              match;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i >= WIN_MAX_LOG2 - int'(len));
    end
    match = (((addr ^ base) & keep) == '0);
    off   = addr & ~keep;
    hit   = en && !err && match;
  end

  always_comb begin
    bus     = '0;
    dev     = '0;
    fn      = '0;
    reg_off = '0;
    if (hit) begin
      bus     = off[BUS_LSB +: BUS_W];
      dev     = off[DEV_LSB +: DEV_W];
      fn      = off[FN_LSB +: FN_W];
      reg_off = off[REG_W-1:0];
    end
  end
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfgwin_pkg::*;
#(
  parameter int          ADDR_W   = 40,
  parameter int          BASE_MSB = 38,
  parameter logic [63:0] RST_VAL  = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_hi,
  input  logic [31:0]       cfg_wr_data,
  input  logic [3:0]        cfg_wr_be,
  output logic [63:0]       cfg_q,
  output logic              win_en,
  output logic              win_err,
  output logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              win_hit,
  output logic [7:0]        tgt_bus,
  output logic [4:0]        tgt_dev,
  output logic [2:0]        tgt_fn,
  output logic [11:0]       tgt_reg
);
  win_len_e win_len;

  cfgwin_reg #(.RST_VAL(RST_VAL)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_hi   (cfg_wr_hi),
    .wr_data (cfg_wr_data),
    .wr_be   (cfg_wr_be),
    .q       (cfg_q)
  );

  cfgwin_size_decode #(.ADDR_W(ADDR_W), .BASE_MSB(BASE_MSB)) u_dec (
    .cfg  (cfg_q),
    .en   (win_en),
    .err  (win_err),
    .len  (win_len),
    .base (win_base)
  );

  cfgwin_hit #(.ADDR_W(ADDR_W)) u_hit (
    .addr    (mem_addr),
    .en      (win_en),
    .err     (win_err),
    .len     (win_len),
    .base    (win_base),
    .hit     (win_hit),
    .bus     (tgt_bus),
    .dev     (tgt_dev),
    .fn      (tgt_fn),
    .reg_off (tgt_reg)
  );

  // R2: no hit while the stored enable bit is clear
  a_r2_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> !win_hit);
  // R4: reserved length code flags an error and blocks hits
  a_r4_rsvd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[2:1] == 2'b11) |-> (win_err && !win_hit));
  // R5: decoded base never carries bits below the smallest window
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[WIN_MIN_LOG2-1:0] == '0);
  // R6: a hit address is never below the base
  a_r6_hit_above_base: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (mem_addr >= win_base));
  // R7: the bus number narrows for the 64 MB window
  a_r7_bus_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && cfg_q[2:1] == 2'b10) |-> (tgt_bus[7:6] == 2'b00));
  // R8: all target fields are 0 when there is no hit
  a_r8_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (tgt_bus == '0 && tgt_dev == '0 && tgt_fn == '0 && tgt_reg == '0));
endmodule

// File: tb/tb_cfg_window_decoder.sv
module tb_cfg_window_decoder;
  localparam int          ADDR_W  = 40;
  localparam logic [63:0] RST_VAL = 64'h0000_0000_B000_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic              cfg_wr_hi = 1'b0;
  logic [31:0]       cfg_wr_data = '0;
  logic [3:0]        cfg_wr_be = '0;
  logic [63:0]       cfg_q;
  logic              win_en, win_err, win_hit;
  logic [ADDR_W-1:0] win_base;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [7:0]        tgt_bus;
  logic [4:0]        tgt_dev;
  logic [2:0]        tgt_fn;
  logic [11:0]       tgt_reg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_hi(cfg_wr_hi),
    .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .cfg_q(cfg_q),
    .win_en(win_en), .win_err(win_err), .win_base(win_base),
    .mem_addr(mem_addr), .win_hit(win_hit), .tgt_bus(tgt_bus),
    .tgt_dev(tgt_dev), .tgt_fn(tgt_fn), .tgt_reg(tgt_reg)
  );

  // Reference register: byte-wise update, behavioural
  logic [63:0] m_reg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reg <= RST_VAL;
    else if (cfg_wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (cfg_wr_be[k]) m_reg[(cfg_wr_hi ? 32 : 0) + k*8 +: 8] <= cfg_wr_data[k*8 +: 8];
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      longint unsigned a, sz, base, off;
      int code;
      bit e_hit;
      a = 64'(mem_addr);
      code = int'(m_reg[2:1]);
      sz = (code == 3) ? 64'd1 << 25 : (64'd1 << (28 - code));
      base = m_reg & ((64'd1 << 39) - 1) & ~(sz - 1);
      e_hit = m_reg[0] && code != 3 && a >= base && a < base + sz;
      off = e_hit ? a - base : 0;
      chk("R1/R9 register value", cfg_q, m_reg);
      chk("R2 enable", 64'(win_en), 64'(m_reg[0]));
      chk("R4 reserved flag", 64'(win_err), 64'(code == 3));
      if (code != 3) chk("R3/R5 base", 64'(win_base), base);
      chk("R6 hit", 64'(win_hit), 64'(e_hit));
      chk("R7/R8 bus", 64'(tgt_bus), off >> 20);
      chk("R7/R8 dev", 64'(tgt_dev), (off >> 15) & 31);
      chk("R7/R8 fn", 64'(tgt_fn), (off >> 12) & 7);
      chk("R7/R8 reg", 64'(tgt_reg), off & 12'hFFF);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input bit hi, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_hi = hi; cfg_wr_data = d; cfg_wr_be = be;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic probe(input longint unsigned a);
    @(posedge clk); #1;
    mem_addr = a[ADDR_W-1:0];
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 reset value", cfg_q, RST_VAL);
    chk("R2 reset enable", 64'(win_en), 0);
    chk("R8 reset hit", 64'(win_hit), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;
    // R2: default base with enable clear
    probe(64'hB000_0000); probe(64'hB123_4567);
    // R3: 256 MB window at 0xC000_0000
    wr(0, 32'hC000_0001, 4'hF);
    probe(64'hC000_0000); probe(64'hCFFF_FFFF); probe(64'hD000_0000);
    probe(64'hBFFF_FFFF);
    probe(64'hC000_0000 | (64'h5A << 20) | (64'h13 << 15) | (64'h5 << 12) | 64'h7FC);
    // R9 + R3: single-byte write switches to 128 MB
    wr(0, 32'h0000_0003, 4'h1);
    probe(64'hC7FF_FFFF); probe(64'hC800_0000);
    wr(0, 32'hC800_0000, 4'h8);
    probe(64'hC800_0000); probe(64'hCFFF_FFFF); probe(64'hC7FF_FFFF);
    // R3/R5: 64 MB window, base bit 26 now significant
    wr(0, 32'h0000_0005, 4'h1);
    probe(64'hCC00_0000); probe(64'hC800_0000); probe(64'hCBFF_FFFF);
    wr(0, 32'hCC00_0000, 4'h8);
    probe(64'hCC00_0000); probe(64'hCFFF_FFFF); probe(64'hD000_0000);
    // R9: upper half moves base above 4 GB
    wr(1, 32'h0000_0001, 4'h1);
    probe(64'hCC00_0000); probe(64'h1_CC00_0000); probe(64'h1_CFFF_F123);
    // R5/R6: bits above the base field stored but ignored
    wr(1, 32'hFFFF_FF81, 4'hF);
    probe(64'h1_CC00_0000); probe(64'h81_CC00_0000);
    // R4: reserved length code
    wr(0, 32'h0000_0007, 4'h1);
    probe(64'h1_CC00_0000); probe(64'h1_CE00_0000);
    // R2: disabled with valid length
    wr(0, 32'h0000_0004, 4'h1);
    probe(64'h1_CC00_0000);
    // Randomized phase
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(3) == 0)
        wr(1'($urandom_range(1)), $urandom, 4'($urandom_range(15)));
      else begin
        longint unsigned b;
        b = 64'(cfg_q) & ((64'd1 << 39) - 1) & ~((64'd1 << 26) - 1);
        probe(b + {32'h0, $urandom} + (longint'($urandom_range(3)) << 26) - 64'h1000);
      end
    end
    @(posedge clk); @(negedge clk);
    running = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule